// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words and returns the product one clock after the operands are presented. Each word holds a sign bit at bit 31, an 8-bit exponent biased by 127 at bits 30:23, and a 23-bit fraction at bits 22:0. The fraction carries an implied leading one whenever the exponent field is nonzero. A caller drives both operands with `in_valid` high. On the next rising edge the block registers the product and raises `out_valid`.

For ordinary operands, the block works in these steps:
- It forms the result sign as the exclusive-OR of the two operand signs.
- It adds the two biased exponents and subtracts one bias.
- It multiplies the two 24-bit significands, hidden bit included, as unsigned integers into a 48-bit product.
- It shifts the product right by at most one place to normalise it.
- It rounds to 23 fraction bits by round-to-nearest, ties to even.

Special encodings are recognised and propagated. Results outside the exponent range saturate to infinity or flush to a signed zero. The block produces no subnormal results and raises no flags.

Top module: `fp32_mul`

## Requirements
- R1: When `in_valid` is high at a rising edge, `out_valid` is high after that edge and `result` holds the product of the operands sampled at that edge.
- R2: When `in_valid` is low at a rising edge, `out_valid` is low after that edge and `result` keeps its previous value, whatever the operand inputs carry.
- R3: While `rst_n` is low, `out_valid` and `result` are both zero.
- R4: For every result that is not a NaN, bit 31 of `result` equals the exclusive-OR of bit 31 of the two operands.
- R5: For two operands with exponent fields in 1..254, the exponent is e_a + e_b − 127. The 24-bit significands (hidden 1 plus fraction) are multiplied unsigned. When product bit 47 is set, the significand is taken from bits 46:24 and the exponent rises by one; otherwise the significand is taken from bits 45:23.
- R6: Rounding is to nearest with ties to even. The first discarded product bit is the guard bit and the OR of all lower bits is the sticky bit. A carry out of the rounded fraction clears the fraction and raises the exponent by one.
- R7: If either operand is a NaN (exponent field 255, fraction nonzero), or one operand is infinite and the other is zero, `result` is the quiet NaN 0x7FC00000.
- R8: An infinity (exponent field 255, fraction zero) times a nonzero non-NaN value gives exponent field 255 and fraction 0, with the sign of R4.
- R9: An operand with exponent field 0 counts as zero, whatever its fraction. Times a non-NaN, non-infinite value, it gives bits 30:0 of `result` equal to zero, with the sign of R4.
- R10: A final exponent (after normalisation and rounding) of 255 or more gives a signed infinity.
- R11: A final exponent of 0 or less gives a signed zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands are presented this cycle |
| op_a | input | 32 | First floating-point operand |
| op_b | input | 32 | Second floating-point operand |
| out_valid | output | 1 | `result` holds a new product |
| result | output | 32 | Registered floating-point product |

## Verification
The operand pairs fall into three groups, each probing a different part of the datapath:
- **Directed exact products.** These land either side of the normalisation shift, which separates the two significand windows. Tie cases with odd and with even kept fractions show whether ties go to even rather than always up.
- **Range and special cases.** Operands at the exponent extremes exercise saturation and flushing. Every pairing of zero, infinity, NaN and subnormal-coded inputs checks that the special-case priority is right.
- **Random operands.** One random set keeps the exponents near the bias, so that the rounding logic is hit many times. A second set draws full 32-bit words, so that special values and overflow mix with ordinary products.

Idle cycles with changing operands show that results are held and not recomputed.

// File: rtl/fp32_mul_pkg.sv
package fp32_mul_pkg;

    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int EXPX_W  = EXP_W + 3;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fclass_e;

    typedef struct packed {
        logic               sign;
        logic [EXP_W-1:0]   exp;
        logic [SIG_W-1:0]   sig;
        fclass_e            cls;
    } operand_t;

    localparam logic [WORD_W-1:0] QNAN_WORD =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

endpackage

// File: rtl/fp32_unpack.sv
module fp32_unpack
    import fp32_mul_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output operand_t          op_o
);

    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    assign exp_f  = word_i[WORD_W-2 -: EXP_W];
    assign frac_f = word_i[FRAC_W-1:0];

    always_comb begin
        op_o.sign = word_i[WORD_W-1];
        op_o.exp  = exp_f;
        op_o.sig  = {1'b1, frac_f};
        if (exp_f == '0) begin
            op_o.cls = CLS_ZERO;
        end else if (exp_f == {EXP_W{1'b1}}) begin
            op_o.cls = (frac_f == '0) ? CLS_INF : CLS_NAN;
        end else begin
            op_o.cls = CLS_NORM;
        end
    end

endmodule

// File: rtl/fp32_sig_round.sv
module fp32_sig_round
    import fp32_mul_pkg::*;
(
    input  logic [SIG_W-1:0]         sig_a_i,
    input  logic [SIG_W-1:0]         sig_b_i,
    input  logic signed [EXPX_W-1:0] exp_i,
    output logic [FRAC_W-1:0]        frac_o,
    output logic signed [EXPX_W-1:0] exp_o
);

    logic [PROD_W-1:0]         prod;
    logic                      top_bit;
    logic [FRAC_W-1:0]         kept;
    logic                      guard;
    logic                      sticky;
    logic                      rnd_up;
    logic [FRAC_W:0]           rounded;
    logic                      carry;
    logic signed [EXPX_W-1:0]  inc_norm;
    logic signed [EXPX_W-1:0]  inc_rnd;

    assign prod    = sig_a_i * sig_b_i;
    assign top_bit = prod[PROD_W-1];

    always_comb begin
        if (top_bit) begin
            kept   = prod[PROD_W-2 -: FRAC_W];
            guard  = prod[PROD_W-2-FRAC_W];
            sticky = |prod[PROD_W-3-FRAC_W:0];
        end else begin
            kept   = prod[PROD_W-3 -: FRAC_W];
            guard  = prod[PROD_W-3-FRAC_W];
            sticky = |prod[PROD_W-4-FRAC_W:0];
        end
    end

    assign rnd_up   = guard & (sticky | kept[0]);
    assign rounded  = {1'b0, kept} + {{FRAC_W{1'b0}}, rnd_up};
    assign carry    = rounded[FRAC_W];
    assign frac_o   = rounded[FRAC_W-1:0];
    assign inc_norm = {{(EXPX_W-1){1'b0}}, top_bit};
    assign inc_rnd  = {{(EXPX_W-1){1'b0}}, carry};
    assign exp_o    = exp_i + inc_norm + inc_rnd;

endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
    import fp32_mul_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
    } state_t;

    state_t state_d, state_q;

    operand_t opa, opb;

    logic signed [EXPX_W-1:0] exp_sum;
    logic signed [EXPX_W-1:0] exp_fin;
    logic [FRAC_W-1:0]        frac_fin;

    localparam logic signed [EXPX_W-1:0] BIAS_X = EXPX_W'(BIAS);
    localparam logic signed [EXPX_W-1:0] EMAX_X = EXPX_W'(EXP_MAX);

    fp32_unpack u_unpack_a (.word_i(op_a), .op_o(opa));
    fp32_unpack u_unpack_b (.word_i(op_b), .op_o(opb));

    assign exp_sum = $signed({3'b000, opa.exp}) + $signed({3'b000, opb.exp}) - BIAS_X;

    fp32_sig_round u_sig_round (
        .sig_a_i (opa.sig),
        .sig_b_i (opb.sig),
        .exp_i   (exp_sum),
        .frac_o  (frac_fin),
        .exp_o   (exp_fin)
    );

    always_comb begin
        logic sgn, any_nan, any_inf, any_zero;
        sgn      = opa.sign ^ opb.sign;
        any_nan  = (opa.cls == CLS_NAN)  || (opb.cls == CLS_NAN);
        any_inf  = (opa.cls == CLS_INF)  || (opb.cls == CLS_INF);
        any_zero = (opa.cls == CLS_ZERO) || (opb.cls == CLS_ZERO);

        state_d.vld = in_valid;
        state_d.res = state_q.res;
        if (in_valid) begin
            if (any_nan || (any_inf && any_zero)) begin
                state_d.res = QNAN_WORD;
            end else if (any_inf) begin
                state_d.res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else if (any_zero) begin
                state_d.res = {sgn, {(WORD_W-1){1'b0}}};
            end else if (exp_fin >= EMAX_X) begin
                state_d.res = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            end else if (exp_fin <= 0) begin
                state_d.res = {sgn, {(WORD_W-1){1'b0}}};
            end else begin
                state_d.res = {sgn, exp_fin[EXP_W-1:0], frac_fin};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;

endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk
    import fp32_mul_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] op_a,
    input logic [WORD_W-1:0] op_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);

    logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
    logic nan_case, inf_case, zero_case;

    assign a_nan  = (&op_a[WORD_W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
    assign b_nan  = (&op_b[WORD_W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);
    assign a_inf  = (&op_a[WORD_W-2 -: EXP_W]) && !(|op_a[FRAC_W-1:0]);
    assign b_inf  = (&op_b[WORD_W-2 -: EXP_W]) && !(|op_b[FRAC_W-1:0]);
    assign a_zero = !(|op_a[WORD_W-2 -: EXP_W]);
    assign b_zero = !(|op_b[WORD_W-2 -: EXP_W]);

    assign nan_case  = a_nan || b_nan || ((a_inf || b_inf) && (a_zero || b_zero));
    assign inf_case  = (a_inf || b_inf) && !nan_case;
    assign zero_case = (a_zero || b_zero) && !nan_case && !(a_inf || b_inf);

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result)); // R2

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !nan_case) |=> result[WORD_W-1] == $past(op_a[WORD_W-1] ^ op_b[WORD_W-1])); // R4

    AST_NAN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && nan_case) |=> result == QNAN_WORD); // R7

    AST_INF_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && inf_case) |=> result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}); // R8

    AST_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && zero_case) |=> result[WORD_W-2:0] == '0); // R9

endmodule

bind fp32_mul fp32_mul_chk u_fp32_mul_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/fp32_mul_bench.sv
module fp32_mul_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        out_valid;
    logic [31:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] last_res = '0;

    always #2 clk = ~clk;

    fp32_mul u_fp32_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y);
        logic        s;
        int          ex, ey, e;
        logic [47:0] p;
        logic [23:0] m;
        logic [23:0] rest;
        logic        xn, yn, xi, yi, xz, yz;
        s  = x[31] ^ y[31];
        ex = int'(x[30:23]);
        ey = int'(y[30:23]);
        xn = (ex == 255) && (x[22:0] != 0);
        yn = (ey == 255) && (y[22:0] != 0);
        xi = (ex == 255) && (x[22:0] == 0);
        yi = (ey == 255) && (y[22:0] == 0);
        xz = (ex == 0);
        yz = (ey == 0);
        if (xn || yn || ((xi || yi) && (xz || yz))) return 32'h7FC00000;
        if (xi || yi) return {s, 8'hFF, 23'd0};
        if (xz || yz) return {s, 31'd0};
        e = ex + ey - 127;
        p = {24'd0, 1'b1, x[22:0]} * {24'd0, 1'b1, y[22:0]};
        if (p[47]) e = e + 1;
        else p = p << 1;
        m    = {1'b0, p[46:24]};
        rest = p[23:0];
        if (rest > 24'h800000 || (rest == 24'h800000 && m[0])) m = m + 1;
        if (m[23]) e = e + 1;
        if (e >= 255) return {s, 8'hFF, 23'd0};
        if (e <= 0) return {s, 31'd0};
        return {s, e[7:0], m[22:0]};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input string tag);
        logic [31:0] e_v;
        e_v = model(a, b);
        op_a = a;
        op_b = b;
        in_valid = 1'b1;
        @(negedge clk);
        check({tag, " R1 valid"}, {31'd0, out_valid}, 32'd1);
        check(tag, result, e_v);
        last_res = e_v;
    endtask

    task automatic idle(input logic [31:0] a, input logic [31:0] b);
        op_a = a;
        op_b = b;
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 valid low", {31'd0, out_valid}, 32'd0);
        check("R2 result held", result, last_res);
    endtask

    function automatic logic [31:0] mid_word();
        logic [31:0] r;
        r = $urandom;
        r[30:23] = 8'(100 + ($urandom % 55));
        return r;
    endfunction

    initial begin
        #(4 * 150000);
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R3 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R3 result in reset", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        apply(32'h3F800000, 32'h3F800000, "R5 one*one");
        apply(32'h3FC00000, 32'h3FC00000, "R5 shift 1.5*1.5");
        apply(32'h40000000, 32'hC0400000, "R4 2*-3");
        apply(32'h3F800001, 32'h3F800001, "R6 below half");
        apply(32'h3F800001, 32'h3FC00000, "R6 tie odd up");
        apply(32'h3F800003, 32'h3FC00000, "R6 tie even stays");
        apply(32'h3FFFFFFF, 32'h3F800001, "R6 near two");
        apply(32'h7F000000, 32'h7F000000, "R10 overflow");
        apply(32'hFF000000, 32'h7F000000, "R10 neg overflow");
        apply(32'h00800000, 32'h00800000, "R11 underflow");
        apply(32'h80800000, 32'h00800000, "R11 neg underflow");
        apply(32'h7FC00001, 32'h3F800000, "R7 nan in");
        apply(32'h7F800000, 32'h00000000, "R7 inf*zero");
        apply(32'h7F800000, 32'hC0000000, "R8 inf*-2");
        apply(32'hFF800000, 32'hFF800000, "R8 inf*inf");
        apply(32'h00000000, 32'hC0A00000, "R9 zero*-5");
        apply(32'h00000001, 32'h3F800000, "R9 subnormal coded");
        idle(32'h40400000, 32'h40400000);
        idle(32'h7FC00000, 32'h00000000);

        for (int i = 0; i < 1500; i++) begin
            apply(mid_word(), mid_word(), "R5 R6 random mid");
        end
        for (int i = 0; i < 1500; i++) begin
            apply($urandom, $urandom, "R4 R10 R11 random full");
            if ((i % 100) == 0) idle($urandom, $urandom);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule